// File: doc/BRIEF.md
# Voltage-Code Deglitcher and Reference Slew Sequencer

This block sits between the seven voltage-identification inputs of a single-phase buck controller and the reference DAC. It filters the raw code so that bit-to-bit skew during a code transition is never acted on. It turns each accepted code into a reference level in 12.5 mV units. It then moves the reference toward that level one unit at a time, at a rate set by a clock prescaler, so the output never jumps.

On enable, the block first runs a slow soft-start ramp from 0 V up to a 1.1 V boot level. It holds the boot level for a fixed number of step intervals and then slews to the programmed code. A mode flag requests fixed-frequency PWM operation during soft-start and for a retriggerable window after every accepted code change. Outside those windows the flag requests ramp-pulse operation. The analog DAC and the control loop are outside this block.

Top module: `vid_slew_seq`

## Requirements
- R1: A new input code is acted on only after it has been held unchanged for more than FILT_CYC clock cycles. A code held for FILT_CYC cycles or fewer is discarded, and any change restarts the count. A code that first appears at a clock edge is accepted at the FILT_CYC-th edge after that one.
- R2: `vid_chg` is high for exactly one cycle each time an accepted code differs from the previously accepted one. It is high in the cycle in which the new target takes effect.
- R3: An accepted code c in 1..125 gives target level 129 - c. The level unit is 12.5 mV, so level 128 is 1.6 V. Codes 0, 126 and 127 give level 0. `ref_lvl` never exceeds 128.
- R4: While enabled, `ref_lvl` changes by at most one unit per clock cycle and passes through every intermediate level.
- R5: After boot, the reference takes one unit step per STEP_CYC-cycle tick. A move of d units completes between (d-1)*STEP_CYC+1 and d*STEP_CYC cycles after the `vid_chg` cycle.
- R6: After enable, the reference rises from 0 to the boot level (88, which is 1.1 V), one unit every STEP_CYC*SS_DIV cycles.
- R7: The reference rests at the boot level for exactly BOOT_TICKS*STEP_CYC cycles. It then starts toward the programmed target.
- R8: `at_target` is high only after the boot hold has ended and while `ref_lvl` equals the current target level.
- R9: `pwm_mode` is high throughout soft-start and the boot hold. After each `vid_chg` pulse it stays high for at least (PWM_TICKS-1)*STEP_CYC cycles and at most PWM_TICKS*STEP_CYC+1 cycles. A new change restarts this window.
- R10: While `en` is low, `ref_lvl` is 0, all flags are low and all timers are cleared. A rising `en` restarts the soft-start from level 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low forces shutdown state |
| vid_in | input | 7 | Raw voltage-identification code |
| ref_lvl | output | 8 | Reference level to the DAC, 12.5 mV per unit |
| at_target | output | 1 | Reference equals the programmed target after boot |
| vid_chg | output | 1 | One-cycle pulse on an accepted code change |
| pwm_mode | output | 1 | High requests fixed-frequency PWM, low requests ramp-pulse mode |

## Verification
The reference is driven through every code from 1 up to 127 in unit steps, which checks the decoded level of each code and the off codes. Large jumps in both directions are then timed against the slew window, which separates a correct step rate from a stalled or skipping stepper. Short pulses of exactly the filter length, and skewed multi-code bursts, are fed in to tell a filter that restarts correctly from one that is off by a cycle or that latches an intermediate code. Soft-start spacing, the boot dwell, the mode window and its retrigger, and a mid-run disable are each timed to the cycle.

// File: rtl/vid_pkg.sv
package vid_pkg;
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_RAMP = 2'd1,
        PH_BOOT = 2'd2,
        PH_RUN  = 2'd3
    } phase_e;
endpackage

// File: rtl/vid_filter.sv
module vid_filter #(
    parameter int W        = 7,
    parameter int FILT_CYC = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] vid_in,
    output logic [W-1:0] code,
    output logic         chg
);
    localparam int CW = $clog2(FILT_CYC + 1);

    typedef struct packed {
        logic [W-1:0]  raw;
        logic [W-1:0]  code;
        logic [CW-1:0] cnt;
        logic          chg;
    } flt_t;

    flt_t q, d;

    always_comb begin
        d     = q;
        d.chg = 1'b0;
        if (!en) begin
            d = '0;
        end else if (vid_in != q.raw) begin
            d.raw = vid_in;
            d.cnt = '0;
        end else if (q.cnt != CW'(FILT_CYC - 1)) begin
            d.cnt = q.cnt + 1'b1;
        end else if (q.raw != q.code) begin
            d.code = q.raw;
            d.chg  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign code = q.code;
    assign chg  = q.chg;

    // R2
    code_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && q.code != $past(q.code)) |-> q.chg);
    // R1
    stable_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.chg |-> ($past(en) && $past(q.raw) == q.code));
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
    parameter int STEP_CYC = 50,
    parameter int SS_DIV   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick,
    output logic ss_tick
);
    localparam int PW = $clog2(STEP_CYC + 1);
    localparam int SW = $clog2(SS_DIV + 1);

    typedef struct packed {
        logic [PW-1:0] pcnt;
        logic [SW-1:0] scnt;
    } tk_t;

    tk_t q, d;

    always_comb begin
        d       = q;
        tick    = (q.pcnt == PW'(STEP_CYC - 1));
        ss_tick = tick && (q.scnt == SW'(SS_DIV - 1));
        if (!en) begin
            d = '0;
        end else if (tick) begin
            d.pcnt = '0;
            d.scnt = ss_tick ? '0 : q.scnt + 1'b1;
        end else begin
            d.pcnt = q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5
    prescale_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.pcnt < PW'(STEP_CYC) && q.scnt < SW'(SS_DIV));
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic load,
    input  logic tick,
    output logic busy
);
    localparam int TW = $clog2(TICKS + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en)                         cnt_d = '0;
        else if (load)                   cnt_d = TW'(TICKS);
        else if (tick && cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R9
    load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load) |=> busy);
endmodule

// File: rtl/vid_slew_seq.sv
module vid_slew_seq
    import vid_pkg::*;
#(
    parameter int VID_W      = 7,
    parameter int FILT_CYC   = 20,
    parameter int STEP_CYC   = 50,
    parameter int SS_DIV     = 16,
    parameter int BOOT_TICKS = 70,
    parameter int PWM_TICKS  = 100,
    parameter int BOOT_LVL   = 88
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [VID_W-1:0] vid_in,
    output logic [VID_W:0]   ref_lvl,
    output logic             at_target,
    output logic             vid_chg,
    output logic             pwm_mode
);
    localparam int LVL_W  = VID_W + 1;
    localparam int NCODE  = 1 << VID_W;
    localparam int OFF_LO = NCODE - 3;
    localparam int BW     = $clog2(BOOT_TICKS + 1);

    typedef struct packed {
        phase_e         phase;
        logic [LVL_W-1:0] lvl;
        logic [BW-1:0]  bcnt;
    } seq_t;

    seq_t q, d;

    logic [VID_W-1:0] code;
    logic             tick, ss_tick, hold_busy;
    logic [LVL_W-1:0] tgt;

    vid_filter #(.W(VID_W), .FILT_CYC(FILT_CYC)) u_filt (
        .clk(clk), .rst_n(rst_n), .en(en), .vid_in(vid_in),
        .code(code), .chg(vid_chg)
    );

    tick_gen #(.STEP_CYC(STEP_CYC), .SS_DIV(SS_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .ss_tick(ss_tick)
    );

    hold_timer #(.TICKS(PWM_TICKS)) u_hold (
        .clk(clk), .rst_n(rst_n), .en(en), .load(vid_chg), .tick(tick),
        .busy(hold_busy)
    );

    function automatic logic [LVL_W-1:0] to_lvl(input logic [VID_W-1:0] c);
        if (c == '0 || int'(c) > OFF_LO) return '0;
        return LVL_W'(NCODE + 1) - LVL_W'(c);
    endfunction

    function automatic logic [LVL_W-1:0] toward(input logic [LVL_W-1:0] cur,
                                                input logic [LVL_W-1:0] goal);
        if (cur < goal) return cur + 1'b1;
        if (cur > goal) return cur - 1'b1;
        return cur;
    endfunction

    assign tgt = to_lvl(code);

    always_comb begin
        d = q;
        if (!en) begin
            d = '0;
        end else begin
            unique case (q.phase)
                PH_OFF: d.phase = PH_RAMP;
                PH_RAMP: if (ss_tick) begin
                    d.lvl = q.lvl + 1'b1;
                    if (d.lvl == LVL_W'(BOOT_LVL)) begin
                        d.phase = PH_BOOT;
                        d.bcnt  = '0;
                    end
                end
                PH_BOOT: if (tick) begin
                    if (q.bcnt == BW'(BOOT_TICKS - 1)) begin
                        d.phase = PH_RUN;
                        d.lvl   = toward(q.lvl, tgt);
                    end else begin
                        d.bcnt = q.bcnt + 1'b1;
                    end
                end
                PH_RUN: if (tick) d.lvl = toward(q.lvl, tgt);
                default: d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ref_lvl   = q.lvl;
    assign at_target = (q.phase == PH_RUN) && (q.lvl == tgt);
    assign pwm_mode  = (q.phase == PH_RAMP) || (q.phase == PH_BOOT) || hold_busy;

    // R4
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> (q.lvl == $past(q.lvl) ||
                               q.lvl == $past(q.lvl) + 1'b1 ||
                               q.lvl + 1'b1 == $past(q.lvl)));
    // R5
    step_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && q.lvl != $past(q.lvl)) |-> $past(tick));
    // R3
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.lvl <= LVL_W'(NCODE));
    // R10
    shutdown_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (q.lvl == '0 && !at_target));
endmodule

// File: tb/tb_vid_slew_seq.sv
module tb_vid_slew_seq;
    localparam int F  = 5;
    localparam int ST = 4;
    localparam int SS = 4;
    localparam int BT = 6;
    localparam int PT = 8;
    localparam int BL = 88;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [6:0] vid_in = 7'd20;
    logic [7:0] ref_lvl;
    logic       at_target, vid_chg, pwm_mode;

    int n_chk = 0, n_bad = 0, cyc = 0, chg_cnt = 0;
    bit finished = 1'b0;

    vid_slew_seq #(.FILT_CYC(F), .STEP_CYC(ST), .SS_DIV(SS), .BOOT_TICKS(BT),
                   .PWM_TICKS(PT), .BOOT_LVL(BL)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .vid_in(vid_in), .ref_lvl(ref_lvl),
        .at_target(at_target), .vid_chg(vid_chg), .pwm_mode(pwm_mode)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int lvl_of(input int c);
        if (c == 0 || c >= 126) return 0;
        return 129 - c;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ref(input int lvl, output int t);
        int n = 0;
        while (int'(ref_lvl) != lvl && n < 5000) begin @(negedge clk); n++; end
        t = cyc;
    endtask

    task automatic wait_tgt(output int t);
        int n = 0;
        while (!at_target && n < 5000) begin @(negedge clk); n++; end
        t = cyc;
    endtask

    task automatic wait_chg(output int t);
        int n = 0;
        while (!vid_chg && n < 200) begin @(negedge clk); n++; end
        t = cyc;
    endtask

    // step-size and spacing monitor
    logic pen = 1'b0;
    int   pref = 0, last_t = -1;
    always @(negedge clk) begin
        if (vid_chg) chg_cnt++;
        if (en && pen && int'(ref_lvl) != pref) begin
            chk(int'(ref_lvl) - pref == 1 || pref - int'(ref_lvl) == 1,
                "R4 unit step", int'(ref_lvl) - pref, 1);
            if (last_t >= 0)
                chk(cyc - last_t >= ST, "R5 step spacing", cyc - last_t, ST);
            last_t = cyc;
        end
        if (!en) last_t = -1;
        pen  = en;
        pref = int'(ref_lvl);
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int t1, t2, tb_, te, tc, ta, c0, r0, d;
        int jumps[5] = '{1, 125, 64, 2, 100};
        int prev;
        step(3);
        rst_n = 1'b1;
        step(3);
        // R10 reset / disabled state
        chk(ref_lvl == 0 && !at_target && !vid_chg && !pwm_mode, "R10 idle outputs",
            int'(ref_lvl), 0);

        en = 1'b1;
        wait_ref(1, t1);
        wait_ref(2, t2);
        chk(t2 - t1 == ST * SS, "R6 soft-start spacing", t2 - t1, ST * SS);
        chk(pwm_mode == 1'b1, "R9 pwm in soft-start", pwm_mode, 1);
        wait_ref(BL, tb_);
        chk(at_target == 1'b0, "R8 no target in boot", at_target, 0);
        chk(pwm_mode == 1'b1, "R9 pwm in boot hold", pwm_mode, 1);
        wait_ref(BL + 1, te);
        chk(te - tb_ == BT * ST, "R7 boot dwell", te - tb_, BT * ST);
        wait_tgt(ta);
        chk(int'(ref_lvl) == lvl_of(20), "R3 boot then target", int'(ref_lvl), lvl_of(20));
        chk(pwm_mode == 1'b0, "R9 ramp-pulse when settled", pwm_mode, 0);

        // acceptance latency and pulse width
        vid_in = 7'd30;
        step(F);
        chk(vid_chg == 1'b0, "R1 not before filter", vid_chg, 0);
        step(1);
        chk(vid_chg == 1'b1, "R2 pulse at acceptance", vid_chg, 1);
        tc = cyc;
        step(1);
        chk(vid_chg == 1'b0, "R2 single-cycle pulse", vid_chg, 0);
        chk(pwm_mode == 1'b1, "R9 pwm after change", pwm_mode, 1);
        step((PT - 1) * ST - 2);
        chk(pwm_mode == 1'b1, "R9 pwm window min", pwm_mode, 1);
        step(ST + 2);
        chk(pwm_mode == 1'b0, "R9 pwm window max", pwm_mode, 0);
        wait_tgt(ta);
        chk(int'(ref_lvl) == lvl_of(30), "R3 level of code 30", int'(ref_lvl), lvl_of(30));

        // retrigger of mode window
        vid_in = 7'd40;
        wait_chg(tc);
        step(14);
        vid_in = 7'd41;
        wait_chg(tc);
        step((PT - 1) * ST);
        chk(pwm_mode == 1'b1, "R9 retriggered window", pwm_mode, 1);
        step(ST + 2);
        chk(pwm_mode == 1'b0, "R9 retriggered window end", pwm_mode, 0);
        wait_tgt(ta);

        // short glitch of exactly filter length is discarded
        c0 = chg_cnt; r0 = int'(ref_lvl);
        vid_in = 7'd70;
        step(F);
        vid_in = 7'd41;
        step(3 * ST);
        chk(chg_cnt == c0, "R1 glitch ignored", chg_cnt - c0, 0);
        chk(int'(ref_lvl) == r0 && at_target, "R1 reference untouched", int'(ref_lvl), r0);

        // skewed burst settles on the final code only
        c0 = chg_cnt;
        vid_in = 7'd5; step(3);
        vid_in = 7'd6; step(2);
        vid_in = 7'd7; step(F + 4);
        chk(chg_cnt - c0 == 1, "R1 skew burst one accept", chg_cnt - c0, 1);
        wait_tgt(ta);
        chk(int'(ref_lvl) == lvl_of(7), "R1 final skew code", int'(ref_lvl), lvl_of(7));

        // off codes
        vid_in = 7'd0; step(F + 3); wait_tgt(ta);
        chk(ref_lvl == 0, "R3 code 0 off", int'(ref_lvl), 0);
        vid_in = 7'd127; wait_chg(tc); step(2);
        chk(at_target && ref_lvl == 0, "R3 code 127 off", int'(ref_lvl), 0);

        // full sweep of codes in unit steps
        for (int c = 1; c < 128; c++) begin
            vid_in = 7'(c);
            step(F + 3);
            wait_tgt(ta);
            chk(int'(ref_lvl) == lvl_of(c) && at_target, "R3 sweep level",
                int'(ref_lvl), lvl_of(c));
        end

        // large jumps, timed
        prev = 127;
        foreach (jumps[i]) begin
            vid_in = 7'(jumps[i]);
            wait_chg(tc);
            wait_tgt(ta);
            d = lvl_of(jumps[i]) - lvl_of(prev);
            if (d < 0) d = -d;
            chk(ta - tc >= (d - 1) * ST + 1 && ta - tc <= d * ST, "R5 slew duration",
                ta - tc, d * ST);
            chk(int'(ref_lvl) == lvl_of(jumps[i]), "R5 jump endpoint",
                int'(ref_lvl), lvl_of(jumps[i]));
            prev = jumps[i];
        end

        // shutdown and restart
        en = 1'b0;
        step(1);
        chk(ref_lvl == 0 && !pwm_mode && !at_target, "R10 disable clears",
            int'(ref_lvl), 0);
        step(3);
        en = 1'b1;
        t1 = cyc;
        wait_ref(1, t2);
        chk(t2 - t1 <= ST * SS + 2, "R10 restart soft-start", t2 - t1, ST * SS);
        chk(pwm_mode == 1'b1, "R10 pwm on restart", pwm_mode, 1);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule